// File: doc/BRIEF.md
# Fragmented-Input Crypto Job Controller

This block is the control front end of a cipher/hash accelerator. Software fills in a source address, a destination address, a byte count, four mode words and a control word over a simple word-wide register bus, then writes the start register. A sequencer then reads source words one at a time through a request/grant read port. It packs them into 128-bit blocks and hands each block to the processing engine over a valid/ready port. It takes the engine's 128-bit result back and stores the result words through a request/grant write port. The arithmetic itself lives in the engine and is not part of this block.

A job's input may be spread over several separate memory areas. When the control word marks that more input follows, the sequencer parks after using up the current area. Software then loads a fresh source address and byte count, and a new start write continues the same job. The block raises an interrupt when a job ends, if that is enabled. It gates writes to its 64-word key store so that keys can only change while no job is open. It can also run a key-expansion handshake with the engine before the first block.

Register map (byte offsets): control 0x00, start 0x04, source address 0x08, byte count 0x0C, destination address 0x10, status 0x14, interrupt clear 0x18, mode words 0x1C, 0x20, 0x24 and 0x28, key words 0x100 to 0x1FC. Control bits: 4 final-block-only output, 8 interrupt enable, 9 hash mode, 16 more input follows, 17 key expansion request. Status bits: 0 inactive, 1 waiting for input, 2 interrupt pending.

Top module: `fjc_top`

## Requirements
- R1: After reset the status register reads 0x1 (inactive), and every other register, the irq pin and all request outputs read 0.
- R2: Writing 1 to bit 0 of the start register (0x04) while inactive starts a job. The start register always reads 0.
- R3: Source words are read in rising address order and placed into the block lowest word first. Byte lane k of a word occupies bits 8k+7:8k, and blk_last is 1 only for the final block of the final fragment.
- R4: When the bytes left in a fragment do not fill a block, the byte lanes and words past the count are zero in that block.
- R5: The source address grows by 4 per word read. The byte count falls by the bytes taken from each word and stops at zero. The destination address grows by 4 per word written. All three read back as running values.
- R6: With control bit 16 set, the sequencer parks once the fragment is used up: status reads 0x2 and no interrupt is raised.
- R7: While parked, writes to the source address, byte count and control are accepted. A start write clears the waiting bit and continues the same job.
- R8: With control bit 16 clear, status bit 0 returns to 1 once the last result word has been stored. A zero-length last fragment ends the job at once with no memory traffic.
- R9: In cipher mode (bit 9 = 0), bit 4 = 0 stores every result block and bit 4 = 1 stores only the final one. In hash mode only the final result block is stored.
- R10: With control bit 8 set, the end of a job sets status bit 2 and the irq pin. Writing 1 to bit 0 of 0x18 clears both. With bit 8 clear, no interrupt is raised.
- R11: Key-store writes take effect only while status bit 0 is 1. Writes at any other time, including while parked, are dropped.
- R12: With control bit 17 set, a start first runs the key-expansion handshake before any source read, and the hardware then clears bit 17.
- R13: While a job is running and not parked, writes to the configuration registers and start writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 9 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| mrd_req | output | 1 | Source word read request |
| mrd_addr | output | 32 | Source word address |
| mrd_gnt | input | 1 | Read grant; mrd_data valid in the same cycle |
| mrd_data | input | 32 | Source word |
| blk_valid | output | 1 | Block offered to engine |
| blk_data | output | 128 | Packed input block |
| blk_last | output | 1 | Final block of the job |
| blk_ready | input | 1 | Engine accepts the block |
| res_valid | input | 1 | Engine result valid |
| res_data | input | 128 | Engine result block |
| res_ready | output | 1 | Controller accepts the result |
| mwr_req | output | 1 | Result word write request |
| mwr_addr | output | 32 | Result word address |
| mwr_data | output | 32 | Result word |
| mwr_gnt | input | 1 | Write grant |
| kexp_req | output | 1 | Key expansion request to engine |
| kexp_done | input | 1 | Key expansion finished |
| key_idx | input | 6 | Engine key-store read index |
| key_word | output | 32 | Key-store word at key_idx |
| cfg_ctrl | output | 32 | Control word to engine |
| cfg_mode | output | 128 | Mode words to engine |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the parked state between two fragments. The engine must have drained every block of the first fragment, no interrupt may have been raised, and software writes must then be honoured, except for key writes, which must be dropped. The stimulus runs a two-fragment job with final-block-only output, polls status until only the waiting bit is set, then attempts a key write and reprograms the source and count before resuming. A scoreboard filled from the requirements predicts every block (padding included) and every stored word, and compares them as the engine stub and the memory responders see them.

// File: rtl/fjc_pkg.sv
package fjc_pkg;

    // register word indexes (byte offset >> 2)
    localparam logic [4:0] RI_CTRL  = 5'd0;
    localparam logic [4:0] RI_START = 5'd1;
    localparam logic [4:0] RI_SRC   = 5'd2;
    localparam logic [4:0] RI_COUNT = 5'd3;
    localparam logic [4:0] RI_DST   = 5'd4;
    localparam logic [4:0] RI_STAT  = 5'd5;
    localparam logic [4:0] RI_ICLR  = 5'd6;
    localparam logic [4:0] RI_MODE0 = 5'd7;

    // control word bit positions
    localparam int CB_LASTONLY = 4;
    localparam int CB_IRQEN    = 8;
    localparam int CB_HASH     = 9;
    localparam int CB_MORE     = 16;
    localparam int CB_KEXP     = 17;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEXP,
        SQ_FETCH,
        SQ_SEND,
        SQ_RESULT,
        SQ_WRITE,
        SQ_PARK
    } seq_state_e;

endpackage

// File: rtl/fjc_keystore.sv
module fjc_keystore #(
    parameter int DW    = 32,
    parameter int WORDS = 64,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [IW-1:0] widx_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          idle_i,
    input  logic [IW-1:0] ridx_i,
    output logic [DW-1:0] rdata_o
);

    logic [WORDS*DW-1:0] key_d, key_q;
    logic [WORDS-1:0]    wsel;

    // one write strobe per word, only while no job is open
    for (genvar g = 0; g < WORDS; g++) begin : g_wsel
        assign wsel[g] = we_i && idle_i && (widx_i == IW'(g));
    end

    always_comb begin
        key_d = key_q;
        for (int w = 0; w < WORDS; w++) begin
            if (wsel[w]) key_d[w*DW +: DW] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) key_q <= '0;
        else        key_q <= key_d;
    end

    assign rdata_o = key_q[ridx_i*DW +: DW];

    AST_KEY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_i |=> $stable(key_q)); // R11

endmodule

// File: rtl/fjc_cfg_regs.sv
module fjc_cfg_regs
    import fjc_pkg::*;
#(
    parameter int DW    = 32,
    parameter int MODES = 4,
    localparam int MW   = MODES * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [4:0]    ridx_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          open_i,
    input  logic          done_i,
    input  logic          kexp_clr_i,
    output logic [DW-1:0] ctrl_o,
    output logic [MW-1:0] mode_o,
    output logic          pend_o
);

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [MW-1:0] mode;
        logic          pend;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i && open_i) begin
            if (ridx_i == RI_CTRL) cfg_d.ctrl = wdata_i;
            for (int m = 0; m < MODES; m++) begin
                if (ridx_i == RI_MODE0 + 5'(m)) cfg_d.mode[m*DW +: DW] = wdata_i;
            end
        end
        if (kexp_clr_i) cfg_d.ctrl[CB_KEXP] = 1'b0;
        if (we_i && ridx_i == RI_ICLR && wdata_i[0]) cfg_d.pend = 1'b0;
        if (done_i && cfg_q.ctrl[CB_IRQEN]) cfg_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ctrl_o = cfg_q.ctrl;
    assign mode_o = cfg_q.mode;
    assign pend_o = cfg_q.pend;

    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && ridx_i == RI_ICLR && wdata_i[0] && !done_i) |=> !pend_o); // R10
    AST_KEXP_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        kexp_clr_i |=> !ctrl_o[CB_KEXP]); // R12

endmodule

// File: rtl/fjc_sequencer.sv
module fjc_sequencer
    import fjc_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int BW  = 128,
    parameter int LW  = 24,
    localparam int BPW = DW / 8,
    localparam int WPB = BW / DW,
    localparam int WIX = $clog2(WPB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          more_i,
    input  logic          kexp_en_i,
    input  logic          last_only_i,
    input  logic          hash_i,
    input  logic          sw_src_we_i,
    input  logic          sw_cnt_we_i,
    input  logic          sw_dst_we_i,
    input  logic [DW-1:0] sw_wdata_i,
    output logic          mrd_req_o,
    output logic [AW-1:0] mrd_addr_o,
    input  logic          mrd_gnt_i,
    input  logic [DW-1:0] mrd_data_i,
    output logic          blk_valid_o,
    output logic [BW-1:0] blk_data_o,
    output logic          blk_last_o,
    input  logic          blk_ready_i,
    input  logic          res_valid_i,
    input  logic [BW-1:0] res_data_i,
    output logic          res_ready_o,
    output logic          mwr_req_o,
    output logic [AW-1:0] mwr_addr_o,
    output logic [DW-1:0] mwr_data_o,
    input  logic          mwr_gnt_i,
    output logic          kexp_req_o,
    input  logic          kexp_done_i,
    output logic          kexp_clr_o,
    output logic          idle_o,
    output logic          park_o,
    output logic          open_o,
    output logic          done_o,
    output logic [AW-1:0] src_o,
    output logic [LW-1:0] cnt_o,
    output logic [AW-1:0] dst_o
);

    localparam logic [WIX-1:0] LAST_W = WIX'(WPB - 1);
    localparam logic [LW-1:0]  BPW_L  = LW'(BPW);
    localparam logic [AW-1:0]  BPW_A  = AW'(BPW);

    typedef struct packed {
        seq_state_e     st;
        logic [AW-1:0]  src;
        logic [LW-1:0]  cnt;
        logic [AW-1:0]  dst;
        logic [BW-1:0]  blk;
        logic [BW-1:0]  res;
        logic [WIX-1:0] widx;
        logic           fin;
    } seq_t;

    seq_t sq_d, sq_q;

    logic [LW-1:0] take;
    logic [DW-1:0] in_word;
    logic          store_blk;
    seq_state_e    after_blk;

    // bytes taken from the word being read, and zero padding of short words
    assign take = (sq_q.cnt >= BPW_L) ? BPW_L : sq_q.cnt;

    always_comb begin
        for (int b = 0; b < BPW; b++) begin
            in_word[b*8 +: 8] = (LW'(b) < take) ? mrd_data_i[b*8 +: 8] : 8'h00;
        end
    end

    assign store_blk = hash_i ? sq_q.fin : (!last_only_i || sq_q.fin);
    assign after_blk = (sq_q.cnt != '0) ? SQ_FETCH : (sq_q.fin ? SQ_IDLE : SQ_PARK);

    always_comb begin
        sq_d        = sq_q;
        kexp_req_o  = 1'b0;
        kexp_clr_o  = 1'b0;
        mrd_req_o   = 1'b0;
        mwr_req_o   = 1'b0;
        blk_valid_o = 1'b0;
        res_ready_o = 1'b0;
        case (sq_q.st)
            SQ_IDLE: begin
                if (start_i) begin
                    sq_d.blk  = '0;
                    sq_d.widx = '0;
                    sq_d.st   = kexp_en_i ? SQ_KEXP : SQ_FETCH;
                end
            end
            SQ_KEXP: begin
                kexp_req_o = 1'b1;
                if (kexp_done_i) begin
                    kexp_clr_o = 1'b1;
                    sq_d.st    = SQ_FETCH;
                end
            end
            SQ_FETCH: begin
                if (sq_q.cnt == '0) begin
                    sq_d.st = more_i ? SQ_PARK : SQ_IDLE;
                end else begin
                    mrd_req_o = 1'b1;
                    if (mrd_gnt_i) begin
                        sq_d.blk[sq_q.widx*DW +: DW] = in_word;
                        sq_d.src  = sq_q.src + BPW_A;
                        sq_d.cnt  = sq_q.cnt - take;
                        sq_d.widx = sq_q.widx + 1'b1;
                        if (sq_q.widx == LAST_W || sq_q.cnt == take) begin
                            sq_d.st  = SQ_SEND;
                            sq_d.fin = (sq_q.cnt == take) && !more_i;
                        end
                    end
                end
            end
            SQ_SEND: begin
                blk_valid_o = 1'b1;
                if (blk_ready_i) sq_d.st = SQ_RESULT;
            end
            SQ_RESULT: begin
                res_ready_o = 1'b1;
                if (res_valid_i) begin
                    sq_d.res  = res_data_i;
                    sq_d.blk  = '0;
                    sq_d.widx = '0;
                    sq_d.st   = store_blk ? SQ_WRITE : after_blk;
                end
            end
            SQ_WRITE: begin
                mwr_req_o = 1'b1;
                if (mwr_gnt_i) begin
                    sq_d.dst  = sq_q.dst + BPW_A;
                    sq_d.widx = sq_q.widx + 1'b1;
                    if (sq_q.widx == LAST_W) begin
                        sq_d.widx = '0;
                        sq_d.st   = after_blk;
                    end
                end
            end
            SQ_PARK: begin
                if (start_i) begin
                    sq_d.blk  = '0;
                    sq_d.widx = '0;
                    sq_d.st   = SQ_FETCH;
                end
            end
            default: sq_d.st = SQ_IDLE;
        endcase
        // software loads only while no transfer is in flight
        if (open_o) begin
            if (sw_src_we_i) sq_d.src = AW'(sw_wdata_i);
            if (sw_cnt_we_i) sq_d.cnt = sw_wdata_i[LW-1:0];
            if (sw_dst_we_i) sq_d.dst = AW'(sw_wdata_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '{st: SQ_IDLE, default: '0};
        else        sq_q <= sq_d;
    end

    assign idle_o     = (sq_q.st == SQ_IDLE);
    assign park_o     = (sq_q.st == SQ_PARK);
    assign open_o     = idle_o || park_o;
    assign done_o     = (sq_d.st == SQ_IDLE) && !idle_o;
    assign mrd_addr_o = sq_q.src;
    assign blk_data_o = sq_q.blk;
    assign blk_last_o = sq_q.fin;
    assign mwr_addr_o = sq_q.dst;
    assign mwr_data_o = sq_q.res[sq_q.widx*DW +: DW];
    assign src_o      = sq_q.src;
    assign cnt_o      = sq_q.cnt;
    assign dst_o      = sq_q.dst;

    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_req_o && !mrd_gnt_i) |=> (mrd_req_o && $stable(mrd_addr_o))); // R3
    AST_COUNT_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_req_o && mrd_gnt_i) |=> (cnt_o < $past(cnt_o))); // R5
    AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid_o && !blk_ready_i) |=> (blk_valid_o && $stable(blk_data_o))); // R3
    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mwr_req_o && !mwr_gnt_i) |=> (mwr_req_o && $stable(mwr_addr_o))); // R5

endmodule

// File: rtl/fjc_top.sv
module fjc_top
    import fjc_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int BW        = 128,
    parameter int LW        = 24,
    parameter int MODES     = 4,
    parameter int KEY_WORDS = 64,
    localparam int KIW      = $clog2(KEY_WORDS),
    localparam int BUS_AW   = KIW + 3,
    localparam int MW       = MODES * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              mrd_req,
    output logic [AW-1:0]     mrd_addr,
    input  logic              mrd_gnt,
    input  logic [DW-1:0]     mrd_data,
    output logic              blk_valid,
    output logic [BW-1:0]     blk_data,
    output logic              blk_last,
    input  logic              blk_ready,
    input  logic              res_valid,
    input  logic [BW-1:0]     res_data,
    output logic              res_ready,
    output logic              mwr_req,
    output logic [AW-1:0]     mwr_addr,
    output logic [DW-1:0]     mwr_data,
    input  logic              mwr_gnt,
    output logic              kexp_req,
    input  logic              kexp_done,
    input  logic [KIW-1:0]    key_idx,
    output logic [DW-1:0]     key_word,
    output logic [DW-1:0]     cfg_ctrl,
    output logic [MW-1:0]     cfg_mode,
    output logic              irq
);

    logic          aligned, key_sel, reg_we, key_we, start_wr;
    logic [4:0]    ridx;
    logic          idle, park, open, done, kexp_clr, pend;
    logic [AW-1:0] src, dst;
    logic [LW-1:0] cnt;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign key_sel  = bus_addr[BUS_AW-1];
    assign ridx     = bus_addr[6:2];
    assign reg_we   = bus_wr && aligned && !key_sel;
    assign key_we   = bus_wr && aligned && key_sel;
    assign start_wr = reg_we && (ridx == RI_START) && bus_wdata[0];

    fjc_cfg_regs #(.DW(DW), .MODES(MODES)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (reg_we),
        .ridx_i     (ridx),
        .wdata_i    (bus_wdata),
        .open_i     (open),
        .done_i     (done),
        .kexp_clr_i (kexp_clr),
        .ctrl_o     (cfg_ctrl),
        .mode_o     (cfg_mode),
        .pend_o     (pend)
    );

    fjc_keystore #(.DW(DW), .WORDS(KEY_WORDS)) u_keys (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (key_we),
        .widx_i  (bus_addr[KIW+1:2]),
        .wdata_i (bus_wdata),
        .idle_i  (idle),
        .ridx_i  (key_idx),
        .rdata_o (key_word)
    );

    fjc_sequencer #(.AW(AW), .DW(DW), .BW(BW), .LW(LW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_wr),
        .more_i      (cfg_ctrl[CB_MORE]),
        .kexp_en_i   (cfg_ctrl[CB_KEXP]),
        .last_only_i (cfg_ctrl[CB_LASTONLY]),
        .hash_i      (cfg_ctrl[CB_HASH]),
        .sw_src_we_i (reg_we && ridx == RI_SRC),
        .sw_cnt_we_i (reg_we && ridx == RI_COUNT),
        .sw_dst_we_i (reg_we && ridx == RI_DST),
        .sw_wdata_i  (bus_wdata),
        .mrd_req_o   (mrd_req),
        .mrd_addr_o  (mrd_addr),
        .mrd_gnt_i   (mrd_gnt),
        .mrd_data_i  (mrd_data),
        .blk_valid_o (blk_valid),
        .blk_data_o  (blk_data),
        .blk_last_o  (blk_last),
        .blk_ready_i (blk_ready),
        .res_valid_i (res_valid),
        .res_data_i  (res_data),
        .res_ready_o (res_ready),
        .mwr_req_o   (mwr_req),
        .mwr_addr_o  (mwr_addr),
        .mwr_data_o  (mwr_data),
        .mwr_gnt_i   (mwr_gnt),
        .kexp_req_o  (kexp_req),
        .kexp_done_i (kexp_done),
        .kexp_clr_o  (kexp_clr),
        .idle_o      (idle),
        .park_o      (park),
        .open_o      (open),
        .done_o      (done),
        .src_o       (src),
        .cnt_o       (cnt),
        .dst_o       (dst)
    );

    assign irq = pend;

    always_comb begin
        bus_rdata = '0;
        if (!key_sel) begin
            case (ridx)
                RI_CTRL:  bus_rdata = cfg_ctrl;
                RI_SRC:   bus_rdata = DW'(src);
                RI_COUNT: bus_rdata = DW'(cnt);
                RI_DST:   bus_rdata = DW'(dst);
                RI_STAT:  bus_rdata = DW'({pend, park, idle});
                default:  bus_rdata = '0;
            endcase
            for (int m = 0; m < MODES; m++) begin
                if (ridx == RI_MODE0 + 5'(m)) bus_rdata = cfg_mode[m*DW +: DW];
            end
        end
    end

    AST_PARK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(park) && !$past(pend)) |-> !irq); // R6
    AST_NO_TRAFFIC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !(mrd_req || mwr_req || blk_valid)); // R8

endmodule

// File: tb/tb_fjc_top.sv
module tb_fjc_top;
    import fjc_pkg::*;

    localparam logic [127:0] RPAT = {4{32'hC3C3_0F0F}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [8:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         mrd_req, mrd_gnt = 1'b0;
    logic [31:0]  mrd_addr, mrd_data = '0;
    logic         blk_valid, blk_last, blk_ready = 1'b0;
    logic [127:0] blk_data;
    logic         res_valid = 1'b0, res_ready;
    logic [127:0] res_data = '0;
    logic         mwr_req, mwr_gnt = 1'b0;
    logic [31:0]  mwr_addr, mwr_data;
    logic         kexp_req, kexp_done = 1'b0;
    logic [5:0]   key_idx = '0;
    logic [31:0]  key_word, cfg_ctrl;
    logic [127:0] cfg_mode;
    logic         irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [127:0] eb_q[$];
    bit           el_q[$];
    bit           ep_q[$];
    logic [31:0]  ewa_q[$];
    logic [31:0]  ewd_q[$];

    bit fetch_seen = 0;
    bit kexp_first = 0;

    always #4 clk = ~clk;

    fjc_top dut (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_gnt(mrd_gnt), .mrd_data(mrd_data),
        .blk_valid(blk_valid), .blk_data(blk_data), .blk_last(blk_last), .blk_ready(blk_ready),
        .res_valid(res_valid), .res_data(res_data), .res_ready(res_ready),
        .mwr_req(mwr_req), .mwr_addr(mwr_addr), .mwr_data(mwr_data), .mwr_gnt(mwr_gnt),
        .kexp_req(kexp_req), .kexp_done(kexp_done),
        .key_idx(key_idx), .key_word(key_word),
        .cfg_ctrl(cfg_ctrl), .cfg_mode(cfg_mode), .irq(irq)
    );

    function automatic logic [31:0] memw(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A00, ~a[15:0]};
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // driver side of the scoreboard: predict blocks and stored words
    task automatic plan_frag(input logic [31:0] fa, input int nbytes, input bit last_frag,
                             input bit store_all, inout logic [31:0] da);
        int left = nbytes;
        logic [31:0] a = fa;
        while (left > 0) begin
            logic [127:0] blk = '0;
            bit pad = 0;
            for (int w = 0; w < 4; w++) begin
                if (left > 0) begin
                    logic [31:0] word = memw(a);
                    int tk = (left >= 4) ? 4 : left;
                    for (int b = 0; b < 4; b++) if (b >= tk) word[b*8 +: 8] = 8'h00;
                    if (tk < 4) pad = 1;
                    blk[w*32 +: 32] = word;
                    a += 4;
                    left -= tk;
                end else pad = 1;
            end
            eb_q.push_back(blk);
            el_q.push_back(last_frag && left == 0);
            ep_q.push_back(pad);
            if (store_all || (last_frag && left == 0)) begin
                for (int w = 0; w < 4; w++) begin
                    ewa_q.push_back(da);
                    ewd_q.push_back(blk[w*32 +: 32] ^ RPAT[w*32 +: 32]);
                    da += 4;
                end
            end
        end
    endtask

    task automatic wait_stat(input logic [31:0] mask, input logic [31:0] val, input string tag);
        logic [31:0] s;
        int i = 0;
        bread(9'h014, s);
        while ((s & mask) != val && i < 4000) begin
            bread(9'h014, s);
            i++;
        end
        chk(tag, s & mask, val);
    endtask

    // memory read responder with one wait cycle
    int rd_st = 0;
    always @(negedge clk) begin
        if (rd_st == 2) begin
            mrd_gnt = 1'b0; rd_st = 0;
        end else if (mrd_req) begin
            fetch_seen = 1;
            if (rd_st == 0) rd_st = 1;
            else begin
                mrd_gnt = 1'b1; mrd_data = memw(mrd_addr); rd_st = 2;
            end
        end
    end

    // memory write responder and monitor side of the scoreboard
    always @(negedge clk) begin
        if (mwr_gnt) mwr_gnt = 1'b0;
        else if (mwr_req) begin
            if (ewa_q.size() == 0) chk("R9 unexpected store", {96'd0, mwr_addr}, 128'hFFFF);
            else begin
                chk("R5 store addr", {96'd0, mwr_addr}, {96'd0, ewa_q.pop_front()});
                chk("R9 store data", {96'd0, mwr_data}, {96'd0, ewd_q.pop_front()});
            end
            mwr_gnt = 1'b1;
        end
    end

    // engine stub
    int eng = 0;
    logic [127:0] cap;
    always @(negedge clk) begin
        case (eng)
            0: if (blk_valid) begin
                if (eb_q.size() == 0) chk("R3 unexpected block", blk_data, '1);
                else begin
                    bit p = ep_q.pop_front();
                    chk(p ? "R4 padded block" : "R3 block", blk_data, eb_q.pop_front());
                    chk("R3 last flag", {127'd0, blk_last}, {127'd0, el_q.pop_front()});
                end
                cap = blk_data; blk_ready = 1'b1; eng = 1;
            end
            1: begin blk_ready = 1'b0; res_valid = 1'b1; res_data = cap ^ RPAT; eng = 2; end
            default: begin res_valid = 1'b0; eng = 0; end
        endcase
    end

    // key expansion stub
    int kcnt = 0;
    always @(negedge clk) begin
        if (kexp_done) begin kexp_done = 1'b0; kcnt = 0; end
        else if (kexp_req) begin
            kcnt++;
            if (kcnt == 3) begin kexp_done = 1'b1; kexp_first = !fetch_seen; end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, da;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bread(9'h014, r); chk("R1 status", {96'd0, r}, 128'h1);
        bread(9'h000, r); chk("R1 ctrl", {96'd0, r}, 128'h0);
        bread(9'h00C, r); chk("R1 count", {96'd0, r}, 128'h0);
        bread(9'h008, r); chk("R1 src", {96'd0, r}, 128'h0);
        chk("R1 outputs", {124'd0, irq, mrd_req, mwr_req, blk_valid}, 128'h0);

        // R11 key write while inactive
        bwrite(9'h114, 32'hDEAD_BEEF);
        key_idx = 6'd5; #1 chk("R11 key accepted", {96'd0, key_word}, {96'd0, 32'hDEAD_BEEF});

        // job A: single 37-byte fragment, every block stored, irq enabled
        da = 32'h8000;
        plan_frag(32'h1000, 37, 1, 1, da);
        bwrite(9'h008, 32'h1000); bwrite(9'h00C, 37); bwrite(9'h010, 32'h8000);
        bwrite(9'h000, 32'h0000_0100);
        bwrite(9'h004, 32'h1);
        bread(9'h004, r); chk("R2 start reads zero", {96'd0, r}, 128'h0);
        bwrite(9'h00C, 32'h100);          // R13 ignored while running
        bwrite(9'h004, 32'h1);            // R13 ignored while running
        wait_stat(32'h1, 32'h1, "R8 job A ends");
        chk("R8 blocks drained", eb_q.size(), 0);
        chk("R8 stores drained", ewa_q.size(), 0);
        bread(9'h008, r); chk("R5 src running", {96'd0, r}, {96'd0, 32'h1028});
        bread(9'h00C, r); chk("R13 count ends at zero", {96'd0, r}, 128'h0);
        bread(9'h010, r); chk("R5 dst running", {96'd0, r}, {96'd0, 32'h8030});
        bread(9'h014, r); chk("R10 pending", {96'd0, r}, 128'h5);
        chk("R10 irq pin", {127'd0, irq}, 128'h1);
        bwrite(9'h018, 32'h1);
        bread(9'h014, r); chk("R10 cleared", {96'd0, r}, 128'h1);
        chk("R10 irq pin low", {127'd0, irq}, 128'h0);

        // job B: two fragments, only the final block stored
        da = 32'h9000;
        plan_frag(32'h2000, 32, 0, 0, da);
        bwrite(9'h008, 32'h2000); bwrite(9'h00C, 32); bwrite(9'h010, 32'h9000);
        bwrite(9'h000, 32'h0001_0110);
        bwrite(9'h004, 32'h1);
        wait_stat(32'h7, 32'h2, "R6 parked status");
        chk("R6 no irq while parked", {127'd0, irq}, 128'h0);
        bwrite(9'h118, 32'h1234_5678);
        key_idx = 6'd6; #1 chk("R11 key dropped while parked", {96'd0, key_word}, 128'h0);
        plan_frag(32'h3000, 20, 1, 0, da);
        bwrite(9'h008, 32'h3000); bwrite(9'h00C, 20);
        bwrite(9'h000, 32'h0000_0110);
        bread(9'h00C, r); chk("R7 count loaded while parked", {96'd0, r}, 128'd20);
        bwrite(9'h004, 32'h1);
        bread(9'h014, r); chk("R7 resumed running", {96'd0, r & 32'h3}, 128'h0);
        wait_stat(32'h1, 32'h1, "R7 job B ends");
        chk("R9 final-only stores drained", ewa_q.size(), 0);
        bread(9'h010, r); chk("R9 one block stored", {96'd0, r}, {96'd0, 32'h9010});
        bwrite(9'h018, 32'h1);

        // job C: hash mode, irq disabled
        da = 32'hA000;
        plan_frag(32'h4000, 48, 1, 0, da);
        bwrite(9'h008, 32'h4000); bwrite(9'h00C, 48); bwrite(9'h010, 32'hA000);
        bwrite(9'h000, 32'h0000_0200);
        bwrite(9'h004, 32'h1);
        wait_stat(32'h1, 32'h1, "R9 hash job ends");
        bread(9'h010, r); chk("R9 hash stores final only", {96'd0, r}, {96'd0, 32'hA010});
        bread(9'h014, r); chk("R10 no pending when disabled", {96'd0, r}, 128'h1);

        // job D: key expansion first
        da = 32'hB000;
        plan_frag(32'h5000, 16, 1, 1, da);
        bwrite(9'h008, 32'h5000); bwrite(9'h00C, 16); bwrite(9'h010, 32'hB000);
        bwrite(9'h000, 32'h0002_0000);
        fetch_seen = 0; kexp_first = 0;
        bwrite(9'h004, 32'h1);
        wait_stat(32'h1, 32'h1, "R12 job D ends");
        chk("R12 expansion before reads", {127'd0, kexp_first}, 128'h1);
        bread(9'h000, r); chk("R12 bit cleared", {96'd0, r}, 128'h0);
        chk("R2 job D blocks", eb_q.size(), 0);

        // job E: zero-length last fragment
        bwrite(9'h00C, 0); bwrite(9'h000, 32'h0000_0100);
        fetch_seen = 0;
        bwrite(9'h004, 32'h1);
        wait_stat(32'h5, 32'h5, "R8 empty job ends with irq");
        chk("R8 no reads for empty job", {127'd0, fetch_seen}, 128'h0);

        repeat (10) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule